// File: doc/BRIEF.md
# Programmable Serial Frame Controller

This block drives the serial clock and the frame strobes for up to four serial input ports. The system clock is divided by a value from 1 to 16 to make the serial clock, and the result is driven on two identical pins so that it can feed more loads. An external sync pulse restarts the divider phase, so several blocks can share one serial clock phase.

A one-cycle start pulse loads an 8-bit down counter with the programmed frame length. The counter then steps down once per serial clock until it reaches zero. After zero, a separate tail counter runs for a length set by the mode. In the long-tail mode it runs 18 serial clocks and then raises a one-cycle frame-done pulse, which tells a consumer that fresh input data is ready. In the short-tail mode it runs 2 serial clocks and stops without a done pulse.

Each frame strobe compares the counter's upper nibble with its own 4-bit delay and fires when they match and the low nibble is zero. Strobes therefore fall on 16-serial-clock boundaries.

Top module: `serial_frame_ctrl`

## Requirements
- R1: With divide value D = div_sel_i + 1, the serial clock has period D system clocks. It is high for the first ceil(D/2) cycles of each period, and is held high when D = 1. sclk0_o and sclk1_o are always equal.
- R2: A sync_i sampled high at a clock edge starts a new serial period at that edge. In the following cycle the divider phase is 0 and the serial clock is high.
- R3: A start_i sampled high while idle loads the frame counter with frame_len_i and latches mode_i. A start_i sampled while a frame is running has no effect on counting, on strobes or on done timing.
- R4: While running, the counter drops by one on each serial clock tick until it reaches zero. Strobe n (bits of dly_i at [4n+3:4n]) is high while the counter's bits [7:4] equal delay n and bits [3:0] are zero.
- R5: In mode 0, done_o is high for exactly one cycle, (frame_len + 18)·D cycles after the start edge. The frame then ends.
- R6: In mode 1, the frame ends (frame_len + 2)·D cycles after the start edge, and done_o stays low.
- R7: While idle, strobe n follows the live frame_len_i. It is high when frame_len_i[7:4] equals delay n and frame_len_i[3:0] is zero.
- R8: During the tail (after the first tick at which the counter is already zero, until the frame ends) the counter stays at zero and all strobes are low.
- R9: During and right after reset, the block is idle, done_o is low and both serial clock outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle frame start pulse |
| sync_i | input | 1 | Divider phase realign pulse |
| div_sel_i | input | 4 | Divide value minus one |
| frame_len_i | input | 8 | Frame counter load value |
| mode_i | input | 1 | 0: 18-clock tail with done; 1: 2-clock tail, no done |
| dly_i | input | 16 | Four 4-bit strobe delays, strobe n at bits [4n+3:4n] |
| sclk0_o | output | 1 | Serial clock copy 0 |
| sclk1_o | output | 1 | Serial clock copy 1 |
| strobe_o | output | 4 | Frame strobes |
| done_o | output | 1 | One-cycle frame done pulse |

## Verification
Each frame is started together with a sync pulse, so the serial ticks fall at known multiples of D after the start edge. At every cycle t after that edge, the bench computes the expected serial clock, strobes and done from t, D, the frame length and the mode. Each of these results changes in the cycle right after its triggering edge: strobes one cycle after a tick, done exactly (L+18)·D cycles after start, and the clock one cycle after its divider step. The bench samples on the falling edge, half a period after the change. Extra start pulses are placed inside running frames, and the done timing and strobe pattern must stay unchanged.

// File: rtl/serial_frame_ctrl.sv
module serial_frame_ctrl #(
  parameter int CNT_W      = 8,
  parameter int DIV_W      = 4,
  parameter int TAIL_W     = 5,
  parameter int NSTB       = 4,
  parameter int LONG_TAIL  = 18,
  parameter int SHORT_TAIL = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         sync_i,
  input  logic [DIV_W-1:0]             div_sel_i,
  input  logic [CNT_W-1:0]             frame_len_i,
  input  logic                         mode_i,
  input  logic [NSTB*(CNT_W-4)-1:0]    dly_i,
  output logic                         sclk0_o,
  output logic                         sclk1_o,
  output logic [NSTB-1:0]              strobe_o,
  output logic                         done_o
);
  localparam int LO_W = 4;
  localparam int HI_W = CNT_W - LO_W;

  logic [DIV_W-1:0]  div_q, div_nxt;
  logic [DIV_W:0]    hi_len;
  logic              sclk_q, tick;
  logic [CNT_W-1:0]  cnt_q, src;
  logic [TAIL_W-1:0] tail_q, tail_last;
  logic              busy_q, mode_q, done_q, hold;

  assign tick      = (div_q == div_sel_i);
  assign div_nxt   = (sync_i || tick) ? '0 : div_q + 1'b1;
  assign hi_len    = ({1'b0, div_sel_i} + (DIV_W+1)'(2)) >> 1;
  assign tail_last = mode_q ? TAIL_W'(SHORT_TAIL - 1) : TAIL_W'(LONG_TAIL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
      cnt_q  <= '0;
      tail_q <= '0;
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      div_q  <= div_nxt;
      sclk_q <= ({1'b0, div_nxt} < hi_len);
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= frame_len_i;
          mode_q <= mode_i;
          tail_q <= '0;
        end
      end else if (tick) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (tail_q == tail_last) begin
          busy_q <= 1'b0;
          tail_q <= '0;
          done_q <= !mode_q;
        end else begin
          tail_q <= tail_q + 1'b1;
        end
      end
    end
  end

  assign src  = busy_q ? cnt_q : frame_len_i;
  assign hold = busy_q && (tail_q != '0);

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    assign strobe_o[g] = !hold && (src[CNT_W-1:LO_W] == dly_i[g*HI_W +: HI_W])
                         && (src[LO_W-1:0] == '0);
  end

  assign sclk0_o = sclk_q;
  assign sclk1_o = sclk_q;
  assign done_o  = done_q;
endmodule

module serial_frame_ctrl_chk #(
  parameter int CNT_W  = 8,
  parameter int TAIL_W = 5,
  parameter int NSTB   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              sync_i,
  input logic              sclk0_o,
  input logic              sclk1_o,
  input logic              done_o,
  input logic              busy_q,
  input logic              tick,
  input logic              mode_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [TAIL_W-1:0] tail_q,
  input logic [NSTB-1:0]   strobe_o
);
  assert_clk_copies_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk0_o == sclk1_o);

  assert_sync_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> sclk0_o);

  assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !tick) |=> (cnt_q == $past(cnt_q)));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tick && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_no_done_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mode_q);

  assert_tail_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tail_q != '0) |-> (strobe_o == '0 && cnt_q == '0));
endmodule

bind serial_frame_ctrl serial_frame_ctrl_chk #(.CNT_W(CNT_W), .TAIL_W(TAIL_W), .NSTB(NSTB)) u_chk (.*);

// File: tb/sim_serial_frame_ctrl.sv
module sim_serial_frame_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        sync_i = 1'b0;
  logic [3:0]  div_sel_i = '0;
  logic [7:0]  frame_len_i = 8'h05;
  logic        mode_i = 1'b0;
  logic [15:0] dly_i = '0;
  logic        sclk0_o, sclk1_o, done_o;
  logic [3:0]  strobe_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sync_i(sync_i),
    .div_sel_i(div_sel_i), .frame_len_i(frame_len_i), .mode_i(mode_i),
    .dly_i(dly_i), .sclk0_o(sclk0_o), .sclk1_o(sclk1_o),
    .strobe_o(strobe_o), .done_o(done_o)
  );

  task automatic check(string req, logic ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] idle_stb(int len, logic [15:0] d);
    logic [3:0] r;
    for (int n = 0; n < 4; n++)
      r[n] = ((len & 15) == 0) && (((len >> 4) & 15) == int'(d[n*4 +: 4]));
    return r;
  endfunction

  function automatic logic [3:0] exp_stb(int t, int len, int dv, int tl, logic [15:0] d);
    int k = t / dv;
    if (k >= len + tl) return idle_stb(len, d);
    if (k > len) return 4'b0;
    return idle_stb(len - k, d);
  endfunction

  task automatic run_frame(int len, int dsel, logic md, logic [15:0] d, int extra);
    int dv = dsel + 1;
    int tl = md ? 2 : 18;
    int fin = (len + tl) * dv;
    string tag;
    @(negedge clk);
    div_sel_i = 4'(dsel); frame_len_i = 8'(len); mode_i = md; dly_i = d;
    start_i = 1'b1; sync_i = 1'b1;
    for (int t = 0; t <= fin + 3; t++) begin
      @(negedge clk);
      start_i = 1'b0; sync_i = 1'b0;
      tag = (t < dv) ? "R2" : "R1";
      check(tag, sclk0_o == ((t % dv) < (dv + 1) / 2) && sclk1_o == sclk0_o,
            {sclk1_o, sclk0_o}, (t % dv) < (dv + 1) / 2);
      if (t / dv >= len + tl) tag = "R7";
      else if (t / dv > len) tag = "R8";
      else tag = "R4";
      if (extra >= 0) tag = "R3";
      check(tag, strobe_o == exp_stb(t, len, dv, tl, d), strobe_o, exp_stb(t, len, dv, tl, d));
      tag = (extra >= 0) ? "R3" : (md ? "R6" : "R5");
      check(tag, done_o == (!md && t == fin), done_o, !md && t == fin);
      if (t == extra) start_i = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int len, dsel, ex;
    logic md;
    logic [15:0] d;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R9", sclk0_o && sclk1_o && !done_o && strobe_o == 4'b0,
          {done_o, sclk1_o, sclk0_o, strobe_o}, 7'b0110000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", sclk1_o && !done_o && strobe_o == 4'b0, {done_o, sclk1_o, strobe_o}, 6'b010000);
    frame_len_i = 8'h30; dly_i = 16'h0003;
    @(negedge clk);
    check("R7", strobe_o == 4'b0001, strobe_o, 4'b0001);

    run_frame(0, 0, 1'b0, 16'h0000, -1);
    run_frame(8'h30, 2, 1'b1, 16'h0003, 20);
    run_frame(8'h30, 2, 1'b1, 16'h0123, -1);
    run_frame(8'h20, 1, 1'b1, 16'h3210, -1);
    run_frame(255, 15, 1'b0, 16'h0F7F, -1);
    run_frame(1, 3, 1'b0, 16'h0000, 5);

    for (int i = 0; i < 16; i++) begin
      len  = $urandom % 120;
      dsel = $urandom % 16;
      md   = 1'($urandom % 2);
      d    = {4'($urandom % 8), 4'($urandom % 8), 4'($urandom % 8), 4'($urandom % 8)};
      ex   = ($urandom % 2 == 0) ? -1 : int'($urandom % ((len + (md ? 2 : 18)) * (dsel + 1)));
      run_frame(len, dsel, md, d, ex);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule